// File: doc/BRIEF.md
# Serial Byte Transmitter with Queue Status

This block is the transmit half of an asynchronous serial port. Software pushes bytes through a one-cycle write strobe. The bytes are held in a small store and moved one at a time into a shift register. The shift register sends each byte as a frame: one low start bit, eight data bits with the least significant bit first, and one high stop bit. Bit timing comes from an external baud tick, and each bit lasts 16 ticks.

A mode input chooses how deep the store is. In single-character mode it holds one byte, which behaves as a holding register. In queued mode it holds up to 16 bytes, so one interrupt service can load a whole burst.

A status byte reports two conditions:
- Bit 5 is the hold-empty flag. In queued mode it is set only when the whole queue has drained, not when a single slot frees up, so software refills only after a full drain.
- Bit 6 is set when nothing at all remains to be sent.

An interrupt output follows the hold-empty flag through a pending latch. The latch is set when the flag rises and cleared by any write strobe.

Top module: `serial_tx_fifo`

## Requirements
- R1: After reset the serial line is high, the status byte reads 8'h60 (bit 5 and bit 6 set, all other bits always 0), and the interrupt pending latch is set.
- R2: Each frame is sent as follows: a 0 start bit, then data bits 0 to 7 in that order, then a 1 stop bit. Each bit lasts 16 baud ticks. The line is high whenever no frame is in progress.
- R3: If a byte is stored when a stop bit ends, its start bit goes out in the very next cycle. A byte written while the shifter is idle enters the shifter on the clock edge after it was stored.
- R4: In queued mode (mode input 1) up to 16 bytes are stored. A write while 16 bytes are stored is dropped, and the stored bytes and their order are unchanged.
- R5: In single-character mode (mode input 0) one byte is stored. A write while that byte is still stored, including in the cycle it moves into the shifter, is dropped.
- R6: Status bit 5 is 1 exactly when no byte is stored. It reads 0 in the cycle after an accepted write.
- R7: In single-character mode, status bit 5 returns to 1 in the cycle after the stored byte moves into the shifter.
- R8: Status bit 6 is 1 only when no byte is stored and no frame is in progress.
- R9: The interrupt output equals the pending latch ANDed with the interrupt-enable input. The latch is set one cycle after status bit 5 rises from 0 to 1. Any write strobe clears it on the next edge.
- R10: A change of the mode input discards all stored bytes on the next edge, and a write in that cycle is dropped. A frame already in progress finishes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe, one cycle per byte |
| wr_data | input | 8 | Byte to send |
| fifo_mode | input | 1 | 1 = queued mode (16 bytes), 0 = single-character mode |
| irq_en | input | 1 | Enables the hold-empty interrupt |
| baud_tick | input | 1 | One pulse per sixteenth of a bit time |
| txd | output | 1 | Serial output line |
| line_status | output | 8 | Bit 5 hold-empty, bit 6 transmitter empty, other bits 0 |
| irq | output | 1 | Interrupt request |

## Verification
Every stored-state result appears one edge after the cause:
- An accepted write clears bit 5 in the following cycle.
- A store followed by an idle shifter starts the start bit one edge later.
- A rise of bit 5 reaches the interrupt one further edge after that.

The bench reference model advances on the same edge as the design, using only the inputs held stable across that edge. It compares the line, both status bits and the interrupt at the falling edge of every cycle, so each result is checked in the exact cycle it is due. Targeted checks after bursts, overflow writes and mode changes read the status at fixed cycle offsets derived from this timing.

// File: rtl/serial_tx_fifo.sv
module serial_tx_fifo #(
  parameter int DEPTH         = 16,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       fifo_mode,
  input  logic       irq_en,
  input  logic       baud_tick,
  output logic       txd,
  output logic [7:0] line_status,
  output logic       irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int TW = $clog2(TICKS_PER_BIT);
  localparam logic [TW-1:0] TMAX = TW'(TICKS_PER_BIT - 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] count;
  logic          mode_q;
  logic          busy;
  logic [9:0]    frame;
  logic [3:0]    bitn;
  logic [TW-1:0] tk;
  logic          he_q, pend;

  logic          flush, last_tick, pop, push, hold_empty;
  logic [CW-1:0] cap;

  assign flush      = fifo_mode != mode_q;
  assign cap        = fifo_mode ? CW'(DEPTH) : CW'(1);
  assign last_tick  = busy && baud_tick && tk == TMAX && bitn == 4'd9;
  assign pop        = (!busy || last_tick) && count != '0 && !flush;
  assign push       = wr_en && !flush && count < cap;
  assign hold_empty = count == '0;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp     <= '0;
      rp     <= '0;
      count  <= '0;
      mode_q <= 1'b0;
    end else begin
      mode_q <= fifo_mode;
      if (flush) begin
        wp    <= '0;
        rp    <= '0;
        count <= '0;
      end else begin
        if (push) wp <= wp + AW'(1);
        if (pop)  rp <= rp + AW'(1);
        count <= count + CW'(push) - CW'(pop);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      frame <= '1;
      bitn  <= '0;
      tk    <= '0;
    end else if (pop) begin
      busy  <= 1'b1;
      frame <= {1'b1, mem[rp], 1'b0};
      bitn  <= '0;
      tk    <= '0;
    end else if (last_tick) begin
      busy  <= 1'b0;
      frame <= '1;
    end else if (busy && baud_tick) begin
      if (tk == TMAX) begin
        tk    <= '0;
        bitn  <= bitn + 4'd1;
        frame <= {1'b1, frame[9:1]};
      end else begin
        tk <= tk + TW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      he_q <= 1'b1;
      pend <= 1'b1;
    end else begin
      he_q <= hold_empty;
      if (wr_en)                   pend <= 1'b0;
      else if (hold_empty && !he_q) pend <= 1'b1;
    end
  end

  assign txd         = busy ? frame[0] : 1'b1;
  assign line_status = {1'b0, hold_empty && !busy, hold_empty, 5'b0};
  assign irq         = pend && irq_en;
endmodule

// File: rtl/serial_tx_fifo_checks.sv
module serial_tx_fifo_checks #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          fifo_mode,
  input logic          mode_q,
  input logic [CW-1:0] count,
  input logic          txd,
  input logic [7:0]    line_status,
  input logic          irq
);
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  p_single_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> count <= CW'(1));

  p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode != mode_q) |=> count == '0);

  p_write_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fifo_mode == mode_q && count < (fifo_mode ? CW'(DEPTH) : CW'(1)))
    |=> !line_status[5]);

  p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !irq);

  p_idle_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
    line_status[6] |-> (line_status[5] && txd));

  p_unused_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    line_status[7] == 1'b0 && line_status[4:0] == 5'b0);
endmodule

bind serial_tx_fifo serial_tx_fifo_checks #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .fifo_mode(fifo_mode),
  .mode_q(mode_q), .count(count), .txd(txd), .line_status(line_status), .irq(irq)
);

// File: tb/sim_serial_tx_fifo.sv
module sim_serial_tx_fifo;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       fifo_mode = 1'b0;
  logic       irq_en = 1'b1;
  logic       baud_tick = 1'b0;
  logic       txd, irq;
  logic [7:0] line_status;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  serial_tx_fifo u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .fifo_mode(fifo_mode), .irq_en(irq_en), .baud_tick(baud_tick),
    .txd(txd), .line_status(line_status), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) #1 baud_tick = ~baud_tick;

  // reference model
  logic [7:0] q[$];
  bit   m_mode, m_busy, m_heq, m_pend;
  logic [7:0] m_sh;
  int   m_bit, m_tk;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_mode = 0; m_busy = 0; m_heq = 1; m_pend = 1;
      m_bit = 0; m_tk = 0; m_sh = 8'h00;
    end else begin
      int  sz;
      int  cap;
      bit  empty_now, fl, endf, can_load, dopop, dopush;
      sz        = q.size();
      empty_now = (sz == 0);
      cap       = fifo_mode ? 16 : 1;
      fl        = (fifo_mode != m_mode);
      endf      = m_busy && baud_tick && m_tk == 15 && m_bit == 9;
      can_load  = !m_busy || endf;
      dopop     = can_load && sz > 0 && !fl;
      dopush    = wr_en && !fl && sz < cap;
      if (fl) q.delete();
      if (dopop) begin
        m_sh = q.pop_front();
        m_busy = 1; m_bit = 0; m_tk = 0;
      end else if (endf) begin
        m_busy = 0;
      end else if (m_busy && baud_tick) begin
        if (m_tk == 15) begin m_tk = 0; m_bit++; end
        else m_tk++;
      end
      if (dopush) q.push_back(wr_data);
      if (wr_en) m_pend = 0;
      else if (empty_now && !m_heq) m_pend = 1;
      m_heq = empty_now;
      m_mode = fifo_mode;
    end
  end

  function automatic bit exp_txd();
    if (!m_busy) return 1'b1;
    if (m_bit == 0) return 1'b0;
    if (m_bit == 9) return 1'b1;
    return m_sh[m_bit-1];
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit et, e5, e6, ei;
      et = exp_txd();
      e5 = (q.size() == 0);
      e6 = e5 && !m_busy;
      ei = m_pend && irq_en;
      checks += 5;
      if (txd !== et) begin failures++;
        $display("FAIL R2 R3 txd at %0t: act=%b exp=%b", $time, txd, et); end
      if (line_status[5] !== e5) begin failures++;
        $display("FAIL R6 R7 status bit5 at %0t: act=%b exp=%b", $time, line_status[5], e5); end
      if (line_status[6] !== e6) begin failures++;
        $display("FAIL R8 status bit6 at %0t: act=%b exp=%b", $time, line_status[6], e6); end
      if (irq !== ei) begin failures++;
        $display("FAIL R9 irq at %0t: act=%b exp=%b", $time, irq, ei); end
      if ({line_status[7], line_status[4:0]} !== 6'b0) begin failures++;
        $display("FAIL R1 unused status bits at %0t: act=%h exp=00", $time, line_status & 8'h9f); end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic look();
    @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (line_status[6]) break;
    end
    @(posedge clk); #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd === 1'b1, "R1 line after reset", txd, 1);
    chk(line_status === 8'h60, "R1 status after reset", line_status, 8'h60);
    chk(irq === 1'b1, "R1 pending after reset", irq, 1);
    @(posedge clk); #1;

    // single-character mode, second write dropped in load cycle (R5)
    wr(8'hA5);
    wr(8'h3C);
    @(negedge clk);
    chk(line_status[5] === 1'b1, "R7 bit5 back after load", line_status[5], 1);
    chk(line_status[6] === 1'b0, "R8 bit6 low while sending", line_status[6], 0);
    chk(irq === 1'b0, "R9 write cleared pending", irq, 0);
    @(posedge clk); #1;
    step(3);
    wr(8'h11);
    @(negedge clk);
    chk(line_status[5] === 1'b0, "R6 bit5 low after write", line_status[5], 0);
    @(posedge clk); #1;
    wr(8'h22);
    @(negedge clk);
    chk(line_status[5] === 1'b0, "R5 byte still held", line_status[5], 0);
    @(posedge clk); #1;
    wait_idle();
    chk(line_status === 8'h60, "R8 idle after char stream", line_status, 8'h60);
    chk(irq === 1'b1, "R9 pending after drain", irq, 1);
    irq_en = 1'b0;
    look();
    chk(irq === 1'b0, "R9 masked", irq, 0);
    irq_en = 1'b1;

    // queued mode: 18 writes, last dropped (R4)
    fifo_mode = 1'b1;
    step(2);
    for (int i = 0; i < 18; i++) wr(8'(8'h40 + 8'(i * 7)));
    @(negedge clk);
    chk(line_status[5] === 1'b0, "R4 full queue bit5", line_status[5], 0);
    @(posedge clk); #1;
    wait_idle();
    chk(line_status[5] === 1'b1, "R6 bit5 after full drain", line_status[5], 1);

    // mode change mid-stream discards queue (R10)
    for (int i = 0; i < 4; i++) wr(8'(8'hC3 ^ 8'(i)));
    step(5);
    fifo_mode = 1'b0;
    wr(8'h77);
    @(negedge clk);
    chk(line_status[5] === 1'b1, "R10 queue discarded", line_status[5], 1);
    chk(line_status[6] === 1'b0, "R10 frame continues", line_status[6], 0);
    @(posedge clk); #1;
    wait_idle();
    wr(8'h5A);
    step(2);
    wait_idle();
    chk(txd === 1'b1, "R2 line idle at end", txd, 1);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule